// File: doc/BRIEF.md
# Paging Codeword Burst Corrector and Serial Formatter

This block receives one 32-bit paging codeword, presented in parallel with a one-cycle valid strobe, after an address match upstream. Bit 31 is the first bit sent over the air and is the address/message marker. Bits 31..1 form a BCH(31,21) codeword: bit 31 is the coefficient of x^30 and bit 1 is the coefficient of x^0. Bit 0 is an even-parity bit over all 32 bits. The block computes the ten-bit syndrome with generator x^10+x^9+x^8+x^6+x^5+x^3+1. It repairs any single-bit error and any error confined to two adjacent bits within the 31 BCH bits. It then classifies the outcome.

When the corrected marker bit is 1, the word is a message. The block forms a 23-bit result: the 20 corrected message bits, a two-bit error class and a parity flag. It shifts this result out one bit per rate tick, most significant bit first, and generates its own data clock. When the corrected marker bit is 0, the word is an address or idle word. The block then gives a one-cycle stop strobe and sends nothing. A host uses the stop strobe to end reception, and it uses the busy output to pace the next codeword.

Top module: `pgr_burst_fmt`

## Requirements
- R1: A codeword whose syndrome is zero passes its message bits (codeword bits 30..11) unchanged, with error class {E0,E1} = 00.
- R2: A single flipped bit anywhere in codeword bits 31..1 is corrected, and the error class is {E0,E1} = 10.
- R3: Two flipped adjacent bits anywhere in codeword bits 31..1 are corrected, and the error class is {E0,E1} = 01.
- R4: Two flipped non-adjacent bits are not corrected. The received bits 30..11 are sent as they are, the marker decision uses the received bit 31, and the error class is {E0,E1} = 11.
- R5: The parity flag is the XOR of all 32 received bits (1 means even parity failed before correction). It is independent of the error class, so an error in bit 0 alone gives class 00 with parity flag 1.
- R6: The serial word is 23 bits, sent MSB first: corrected bits 30..11, then E0, then E1, then the parity flag.
- R7: If the corrected bit 31 is 0, stop_pulse is high for exactly the one cycle after the valid strobe, busy stays low and no data clock is produced. If the corrected bit 31 is 1, no stop is given, even when the received bit 31 was 0.
- R8: Each bit is sent on a rate tick. In the clock cycle after a tick, ser_clk goes low and ser_data takes the new bit at that same edge. ser_clk returns high one cycle later and stays high whenever no bit is being launched. ser_data changes only when ser_clk falls. Ticks are at least two cycles apart.
- R9: busy rises in the cycle after an accepted message strobe and falls at the rising edge of ser_clk for the 23rd bit. A valid strobe while busy is high is ignored and causes no stop and no change to the word in flight.
- R10: After reset: ser_clk = 1, ser_data = 0, busy = 0, stop_pulse = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_valid | input | 1 | One-cycle strobe, cw_in is valid |
| cw_in | input | 32 | Received codeword, bit 31 first on air |
| bit_tick | input | 1 | One-cycle pulse per output bit period |
| ser_data | output | 1 | Serial result, MSB first |
| ser_clk | output | 1 | Generated data clock, data stable at its rising edge |
| stop_pulse | output | 1 | One-cycle strobe: address or idle word seen |
| busy | output | 1 | High while a 23-bit result is being shifted out |

## Verification
Correction and classification are combinational on the strobe cycle. busy or stop_pulse is therefore due at the first falling clock edge after the strobe is sampled, and the bench checks it there. Each serial bit launches at the clock edge after a tick and is latched by the bench at the next rise of ser_clk. The bench compares the assembled 23-bit word one full cycle after busy falls, so that capturing the last bit and seeing busy go low never race. A monitor checks every fall of ser_clk against the tick level held at that edge, and checks every change of ser_data against a low ser_clk. After an intruding strobe, the bench checks stop_pulse exactly one cycle later.

// File: rtl/pgr_burst_fmt.sv
module pgr_burst_fmt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cw_valid,
  input  logic [31:0] cw_in,
  input  logic        bit_tick,
  output logic        ser_data,
  output logic        ser_clk,
  output logic        stop_pulse,
  output logic        busy
);
  localparam int BCH_N = 31;
  localparam int CHK_W = 10;
  localparam int OUT_W = 23;
  localparam int CNT_W = $clog2(OUT_W + 1);
  localparam logic [CHK_W-1:0] GEN_LO = 10'h369;

  function automatic logic [CHK_W-1:0] syn_of(input logic [BCH_N-1:0] v);
    logic [CHK_W-1:0] r;
    r = '0;
    for (int i = BCH_N - 1; i >= 0; i--)
      r = r[CHK_W-1] ? ({r[CHK_W-2:0], v[i]} ^ GEN_LO) : {r[CHK_W-2:0], v[i]};
    return r;
  endfunction

  logic [BCH_N-1:0] rx, flip, fixed;
  logic [CHK_W-1:0] syn;
  logic             hit1, hit2, miss;
  logic [OUT_W-1:0] word, shreg;
  logic [CNT_W-1:0] left;

  assign rx  = cw_in[31:1];
  assign syn = syn_of(rx);

  always_comb begin
    flip = '0;
    hit1 = 1'b0;
    hit2 = 1'b0;
    for (int j = 0; j < BCH_N; j++)
      if (syn == syn_of(BCH_N'(1) << j)) begin
        flip = BCH_N'(1) << j;
        hit1 = 1'b1;
      end
    for (int j = 0; j < BCH_N - 1; j++)
      if (syn == syn_of(BCH_N'(3) << j)) begin
        flip = BCH_N'(3) << j;
        hit2 = 1'b1;
      end
  end

  assign miss  = (syn != '0) && !hit1 && !hit2;
  assign fixed = rx ^ flip;
  assign word  = {fixed[29:10], hit1 | miss, hit2 | miss, ^cw_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      left       <= '0;
      busy       <= 1'b0;
      ser_clk    <= 1'b1;
      ser_data   <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      stop_pulse <= 1'b0;
      if (!busy) begin
        if (cw_valid) begin
          if (fixed[BCH_N-1]) begin
            shreg <= word;
            left  <= CNT_W'(OUT_W);
            busy  <= 1'b1;
          end else begin
            stop_pulse <= 1'b1;
          end
        end
      end else if (!ser_clk) begin
        ser_clk <= 1'b1;
        if (left == '0) busy <= 1'b0;
      end else if (bit_tick) begin
        ser_data <= shreg[OUT_W-1];
        shreg    <= {shreg[OUT_W-2:0], 1'b0};
        left     <= left - 1'b1;
        ser_clk  <= 1'b0;
      end
    end
  end
endmodule

module pgr_burst_fmt_chk (
  input logic clk,
  input logic rst_n,
  input logic cw_valid,
  input logic bit_tick,
  input logic ser_data,
  input logic ser_clk,
  input logic stop_pulse,
  input logic busy
);
  localparam int OUT_W = 23;
  logic       clk_q;
  logic [4:0] nfall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b1;
      nfall <= '0;
    end else begin
      clk_q <= ser_clk;
      if (!busy) nfall <= '0;
      else if (!ser_clk && clk_q) nfall <= nfall + 1'b1;
    end
  end

  assert_idle_clk_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_clk);
  assert_data_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_data != $past(ser_data)) |-> $fell(ser_clk));
  assert_fall_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> ($past(bit_tick) && $past(busy)));
  assert_busy_from_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cw_valid));
  assert_stop_after_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pulse |-> ($past(cw_valid) && $past(!busy) && !busy));
  assert_bit_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (nfall == 5'(OUT_W)));
endmodule

bind pgr_burst_fmt pgr_burst_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cw_valid(cw_valid), .bit_tick(bit_tick),
  .ser_data(ser_data), .ser_clk(ser_clk), .stop_pulse(stop_pulse), .busy(busy)
);

// File: tb/pgr_burst_fmt_bench.sv
`timescale 1ns/1ps
module pgr_burst_fmt_bench;
  logic clk = 1'b0, rst_n = 1'b0, cw_valid = 1'b0, bit_tick = 1'b0;
  logic [31:0] cw_in = '0;
  logic ser_data, ser_clk, stop_pulse, busy;

  int nchk = 0, nfail = 0, nbits = 0, tcnt = 0, bad_fall = 0, bad_edge = 0;
  logic [22:0] rx_word = '0;
  logic prev_clk = 1'b1, prev_dat = 1'b0, tick_held = 1'b0;

  always #4 clk = ~clk;

  pgr_burst_fmt u_pgr_burst_fmt (.*);

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk && !prev_clk) begin
        rx_word = {rx_word[21:0], ser_data};
        nbits++;
      end
      if (!ser_clk && prev_clk && !tick_held) bad_fall++;
      if (ser_data != prev_dat && ser_clk) bad_edge++;
    end
    prev_clk = ser_clk;
    prev_dat = ser_data;
    tcnt = (tcnt + 1) % 5;
    bit_tick = (tcnt == 0);
    tick_held = bit_tick;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [20:0] m);
    logic [30:0] v;
    v = {m, 10'b0};
    for (int i = 30; i >= 10; i--)
      if (v[i]) v[i-:11] = v[i-:11] ^ 11'h769;
    return {m, v[9:0], ^{m, v[9:0]}};
  endfunction

  function automatic logic [22:0] fmt(input logic [19:0] d, input logic [1:0] cls, input logic pe);
    return {d, cls, pe};
  endfunction

  task automatic xfer(input logic [31:0] c, input logic [22:0] ew, input bit emsg,
                      input bit intrude, input string req);
    int guard;
    @(negedge clk);
    nbits = 0; rx_word = '0; cw_in = c; cw_valid = 1'b1;
    @(negedge clk);
    cw_valid = 1'b0;
    if (emsg) begin
      chk(busy && !stop_pulse, {req, " R9 busy after strobe"}, {busy, stop_pulse}, 2'b10);
      guard = 0;
      while (busy && guard < 3000) begin
        @(negedge clk);
        guard++;
        if (intrude && guard == 30) begin cw_in = 32'h0; cw_valid = 1'b1; end
        if (intrude && guard == 31) begin
          cw_valid = 1'b0;
          chk(!stop_pulse && busy, "R9 strobe while busy ignored", {busy, stop_pulse}, 2'b10);
        end
      end
      @(negedge clk);
      chk(nbits == 23, {req, " R6 bit count"}, nbits, 23);
      chk(rx_word == ew, {req, " R6 word"}, rx_word, ew);
    end else begin
      chk(stop_pulse && !busy, {req, " R7 stop"}, {busy, stop_pulse}, 2'b01);
      @(negedge clk);
      chk(!stop_pulse && nbits == 0 && ser_clk, {req, " R7 single stop, no clock"},
          {stop_pulse, nbits[3:0]}, 0);
    end
  endtask

  initial begin
    logic [31:0] c, r;
    logic [20:0] m;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(ser_clk && !ser_data && !busy && !stop_pulse, "R10 reset state",
        {ser_clk, ser_data, busy, stop_pulse}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    m = 21'h1ABCDE; c = enc(m);
    xfer(c, fmt(m[19:0], 2'b00, 1'b0), 1, 0, "R1 clean message");
    xfer(c ^ 32'h8000_0000, fmt(m[19:0], 2'b10, 1'b1), 1, 0, "R2 R7 marker bit fixed");
    xfer(c ^ 32'h0000_0001, fmt(m[19:0], 2'b00, 1'b1), 1, 0, "R5 parity bit only");
    xfer(c ^ 32'hC000_0000, fmt(m[19:0], 2'b01, 1'b0), 1, 0, "R3 top pair");
    xfer(c ^ 32'h0000_0006, fmt(m[19:0], 2'b01, 1'b0), 1, 0, "R3 bottom pair");
    r = c ^ 32'h0010_0400;
    xfer(r, fmt(r[30:11], 2'b11, ^r), 1, 0, "R4 random double");
    m = 21'h0F00F1; c = enc(m);
    xfer(c, '0, 0, 0, "R7 clean address");
    xfer(c ^ 32'h8000_0000, '0, 0, 0, "R7 R2 address marker flipped");
    m = 21'h155555; c = enc(m);
    xfer(c, fmt(m[19:0], 2'b00, 1'b0), 1, 1, "R9 intrusion");

    for (int n = 0; n < 70; n++) begin
      int kind, a, b;
      logic [31:0] e;
      logic [1:0] cls;
      logic [22:0] ew;
      bit msg;
      m = 21'($urandom);
      c = enc(m);
      kind = int'($urandom % 4);
      a = int'($urandom % 31);
      e = '0;
      case (kind)
        1: begin e[a+1] = 1'b1; cls = 2'b10; end
        2: begin a = a % 30; e[a+1] = 1'b1; e[a+2] = 1'b1; cls = 2'b01; end
        3: begin
             b = (a + 2 + int'($urandom % 28)) % 31;
             e[a+1] = 1'b1; e[b+1] = 1'b1; cls = 2'b11;
           end
        default: cls = 2'b00;
      endcase
      if ($urandom % 4 == 0) e[0] = 1'b1;
      r = c ^ e;
      if (cls == 2'b11) begin ew = fmt(r[30:11], cls, ^r); msg = r[31]; end
      else begin ew = fmt(m[19:0], cls, ^r); msg = m[20]; end
      case (kind)
        1: xfer(r, ew, msg, 0, "R2 random single");
        2: xfer(r, ew, msg, 0, "R3 random pair");
        3: xfer(r, ew, msg, 0, "R4 random double");
        default: xfer(r, ew, msg, 0, "R1 R5 random clean");
      endcase
    end

    chk(bad_fall == 0, "R8 clock falls only after tick", bad_fall, 0);
    chk(bad_edge == 0, "R8 data changes only on fall", bad_edge, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule